// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block gives software control of a set of general-purpose pins through a small 32-bit register bus. Pins are grouped in banks of 32. Each bank has its own registers. They set the value a pin drives, whether the pin drives at all, the bias resistor on the pin and a 3-bit drive-strength code. Each bank also has registers that choose how a pin's input raises an interrupt.

Inputs pass through a two-stage synchroniser. Each pin can then flag a rising edge, a falling edge, both edges, or an active-high or active-low level. Edge events stay latched until software writes a one to clear them. Level events follow the pin while it stays active. A per-pin mask picks which latched events reach the single interrupt line that serves all banks.

Top module: `gpio_bank_top`

## Requirements
- R1: Bank b occupies byte addresses 0x200*b up to 0x200*b+0x1FF, and pin n is bit n%32 of bank n/32. Register offsets within a bank are: input 0x00, output value 0x04, output enable 0x08, sense type 0x0C, both-edge 0x10, polarity 0x14, mask 0x18, raw status 0x1C, masked status 0x20, clear 0x24, pull direction 0x34, pull enable 0x38, and drive planes 0 to 2 at 0x58, 0x5C and 0x60. An address in a bank number at or above NUM_BANKS reads 0, and writes to it change nothing.
- R2: A write to a writable register is visible on read-back and on the matching pin outputs from the next clock. pinOut carries the output-value register and pinOe the output-enable register. A set enable bit means the pin drives.
- R3: The input register shows a pin's level two clocks after the pin changes, through a two-flop synchroniser.
- R4: On a pin whose type bit is 0 and whose both-edge bit is 0, a rising edge (polarity 1) or a falling edge (polarity 0) sets the raw status bit three clocks after the pin changes. The opposite edge does not set it.
- R5: On an edge pin whose both-edge bit is 1, either transition sets the status, whatever the polarity bit holds.
- R6: With the type bit at 1, the status bit tracks whether the synchronised pin equals the polarity bit. A clear write does not remove it while the level stays active, and it drops once the level goes inactive.
- R7: Writing 1 to a bit of the clear register resets that latched edge status, and writing 0 leaves the status as it was. The clear register and the read-only registers read 0 or keep their own contents when written.
- R8: If an edge event and a clear write hit the same status bit in the same clock, the bit stays set.
- R9: Masked status reads as raw status AND mask, where a mask bit of 1 passes the event. irq is the OR of every masked status bit across all banks.
- R10: pullUpEn is pull enable AND pull direction, and pullDnEn is pull enable AND NOT pull direction. With enable at 0, neither is active.
- R11: Bits k of a pin's 3-bit drive code come from drive plane k at that pin's bit. The code is (mA/2)-1, so code 7 means 16 mA.
- R12: After reset, every register is 0, so irq, pinOe and all status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access this cycle |
| busWr | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from address |
| pinIn | input | NUM_BANKS*32 | Asynchronous pin levels |
| pinOut | output | NUM_BANKS*32 | Output value per pin |
| pinOe | output | NUM_BANKS*32 | Drive enable per pin |
| pullUpEn | output | NUM_BANKS*32 | Pull-up active per pin |
| pullDnEn | output | NUM_BANKS*32 | Pull-down active per pin |
| drvCode | output | NUM_BANKS*96 | 3-bit drive code per pin, pin p at bits 3p+2:3p |
| irq | output | 1 | Combined masked interrupt |

## Verification
Register writes take effect at the clock that captures them, so read-back and pin outputs are checked one cycle after the write is issued. A pin change is first seen in the input register after two clocks. It reaches the raw status, the masked status and irq after three clocks. The checks sample at exactly those cycles and also one cycle earlier, so a missing or extra synchroniser stage shows up. The edge-versus-clear collision is staged by timing the clear write to land on the third clock after the pin toggles.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BANK_PINS = 32;
  localparam int BANK_SPAN_BITS = 9;
  localparam int DRV_BITS = 3;

  typedef enum logic [3:0] {
    REG_DIN, REG_DOUT, REG_OE, REG_TYPE, REG_DUAL, REG_POL, REG_MASK,
    REG_RAW, REG_MSTAT, REG_CLR, REG_PDIR, REG_PEN,
    REG_DRV0, REG_DRV1, REG_DRV2, REG_NONE
  } regId_e;

  typedef struct packed {
    logic   wrStb;
    logic   clrStb;
    logic   rdStb;
    regId_e id;
  } busStrobe_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 12,
  localparam int BANK_W   = ADDR_W - BANK_SPAN_BITS
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strb,
  output logic [BANK_W-1:0] bankIdx
);
  logic [BANK_SPAN_BITS-1:0] offset;
  logic                      bankOk;
  logic                      writable;
  regId_e                    id;

  assign offset  = busAddr[BANK_SPAN_BITS-1:0];
  assign bankIdx = busAddr[ADDR_W-1:BANK_SPAN_BITS];
  assign bankOk  = int'(bankIdx) < NUM_BANKS;

  always_comb begin
    case (offset)
      9'h000:  id = REG_DIN;
      9'h004:  id = REG_DOUT;
      9'h008:  id = REG_OE;
      9'h00C:  id = REG_TYPE;
      9'h010:  id = REG_DUAL;
      9'h014:  id = REG_POL;
      9'h018:  id = REG_MASK;
      9'h01C:  id = REG_RAW;
      9'h020:  id = REG_MSTAT;
      9'h024:  id = REG_CLR;
      9'h034:  id = REG_PDIR;
      9'h038:  id = REG_PEN;
      9'h058:  id = REG_DRV0;
      9'h05C:  id = REG_DRV1;
      9'h060:  id = REG_DRV2;
      default: id = REG_NONE;
    endcase
  end

  always_comb begin
    case (id)
      REG_DOUT, REG_OE, REG_TYPE, REG_DUAL, REG_POL, REG_MASK,
      REG_PDIR, REG_PEN, REG_DRV0, REG_DRV1, REG_DRV2: writable = 1'b1;
      default: writable = 1'b0;
    endcase
  end

  assign strb.id     = id;
  assign strb.wrStb  = busSel & busWr & bankOk & writable;
  assign strb.clrStb = busSel & busWr & bankOk & (id == REG_CLR);
  assign strb.rdStb  = busSel & ~busWr & bankOk & (id != REG_NONE);
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS  = 2,
  parameter int BANK_W     = 3,
  localparam int NUM_PINS  = NUM_BANKS * BANK_PINS,
  localparam int PIX_W     = $clog2(NUM_PINS)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  busStrobe_t                   strb,
  input  logic [BANK_W-1:0]            bankIdx,
  input  logic [31:0]                  busWdata,
  output logic [31:0]                  busRdata,
  input  logic [NUM_PINS-1:0]          pinIn,
  output logic [NUM_PINS-1:0]          pinOut,
  output logic [NUM_PINS-1:0]          pinOe,
  output logic [NUM_PINS-1:0]          pullUpEn,
  output logic [NUM_PINS-1:0]          pullDnEn,
  output logic [NUM_PINS*DRV_BITS-1:0] drvCode,
  output logic                         irq
);
  logic [NUM_PINS-1:0] syncIn, prevQ;
  logic [NUM_PINS-1:0] typeV, dualV, polV, maskV, statV, pdirV, penV;
  logic [DRV_BITS-1:0][NUM_PINS-1:0] drvV;
  logic [NUM_BANKS-1:0] bankIrq;

  gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(pinIn), .syncOut(syncIn)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= syncIn;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hitB;
    logic [BANK_PINS-1:0] doutQ, oeQ, typeQ, dualQ, polQ, maskQ, statQ, pdirQ, penQ;
    logic [DRV_BITS-1:0][BANK_PINS-1:0] drvQ;
    logic [BANK_PINS-1:0] cur, prv, rise, fall, edgeEvt, lvlAct, clrMask, statNext;

    assign hitB = (int'(bankIdx) == b);
    assign cur  = syncIn[b*BANK_PINS +: BANK_PINS];
    assign prv  = prevQ[b*BANK_PINS +: BANK_PINS];
    assign rise = cur & ~prv;
    assign fall = ~cur & prv;
    assign edgeEvt = (dualQ & (rise | fall)) | (~dualQ & ((polQ & rise) | (~polQ & fall)));
    assign lvlAct  = ~(cur ^ polQ);
    assign clrMask = (strb.clrStb && hitB) ? busWdata : '0;
    assign statNext = (typeQ & lvlAct) | (~typeQ & (edgeEvt | (statQ & ~clrMask)));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        doutQ <= '0; oeQ <= '0; typeQ <= '0; dualQ <= '0; polQ <= '0;
        maskQ <= '0; statQ <= '0; pdirQ <= '0; penQ <= '0; drvQ <= '0;
      end else begin
        statQ <= statNext;
        if (strb.wrStb && hitB) begin
          case (strb.id)
            REG_DOUT: doutQ   <= busWdata;
            REG_OE:   oeQ     <= busWdata;
            REG_TYPE: typeQ   <= busWdata;
            REG_DUAL: dualQ   <= busWdata;
            REG_POL:  polQ    <= busWdata;
            REG_MASK: maskQ   <= busWdata;
            REG_PDIR: pdirQ   <= busWdata;
            REG_PEN:  penQ    <= busWdata;
            REG_DRV0: drvQ[0] <= busWdata;
            REG_DRV1: drvQ[1] <= busWdata;
            REG_DRV2: drvQ[2] <= busWdata;
            default: ;
          endcase
        end
      end
    end

    assign pinOut[b*BANK_PINS +: BANK_PINS]   = doutQ;
    assign pinOe[b*BANK_PINS +: BANK_PINS]    = oeQ;
    assign pullUpEn[b*BANK_PINS +: BANK_PINS] = penQ & pdirQ;
    assign pullDnEn[b*BANK_PINS +: BANK_PINS] = penQ & ~pdirQ;
    assign typeV[b*BANK_PINS +: BANK_PINS] = typeQ;
    assign dualV[b*BANK_PINS +: BANK_PINS] = dualQ;
    assign polV[b*BANK_PINS +: BANK_PINS]  = polQ;
    assign maskV[b*BANK_PINS +: BANK_PINS] = maskQ;
    assign statV[b*BANK_PINS +: BANK_PINS] = statQ;
    assign pdirV[b*BANK_PINS +: BANK_PINS] = pdirQ;
    assign penV[b*BANK_PINS +: BANK_PINS]  = penQ;
    assign bankIrq[b] = |(statQ & maskQ);

    for (genvar k = 0; k < DRV_BITS; k++) begin : g_plane
      assign drvV[k][b*BANK_PINS +: BANK_PINS] = drvQ[k];
      for (genvar p = 0; p < BANK_PINS; p++) begin : g_pin
        assign drvCode[(b*BANK_PINS + p)*DRV_BITS + k] = drvQ[k][p];
      end
    end
  end

  assign irq = |bankIrq;

  logic [PIX_W-1:0] baseIdx;
  assign baseIdx = PIX_W'(bankIdx) << $clog2(BANK_PINS);

  always_comb begin
    busRdata = '0;
    if (strb.rdStb) begin
      case (strb.id)
        REG_DIN:   busRdata = syncIn[baseIdx +: BANK_PINS];
        REG_DOUT:  busRdata = pinOut[baseIdx +: BANK_PINS];
        REG_OE:    busRdata = pinOe[baseIdx +: BANK_PINS];
        REG_TYPE:  busRdata = typeV[baseIdx +: BANK_PINS];
        REG_DUAL:  busRdata = dualV[baseIdx +: BANK_PINS];
        REG_POL:   busRdata = polV[baseIdx +: BANK_PINS];
        REG_MASK:  busRdata = maskV[baseIdx +: BANK_PINS];
        REG_RAW:   busRdata = statV[baseIdx +: BANK_PINS];
        REG_MSTAT: busRdata = statV[baseIdx +: BANK_PINS] & maskV[baseIdx +: BANK_PINS];
        REG_PDIR:  busRdata = pdirV[baseIdx +: BANK_PINS];
        REG_PEN:   busRdata = penV[baseIdx +: BANK_PINS];
        REG_DRV0:  busRdata = drvV[0][baseIdx +: BANK_PINS];
        REG_DRV1:  busRdata = drvV[1][baseIdx +: BANK_PINS];
        REG_DRV2:  busRdata = drvV[2][baseIdx +: BANK_PINS];
        default:   busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank_top.sv
module gpio_bank_top
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 12,
  localparam int NUM_PINS = NUM_BANKS * BANK_PINS,
  localparam int BANK_W   = ADDR_W - BANK_SPAN_BITS
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         busSel,
  input  logic                         busWr,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [31:0]                  busWdata,
  output logic [31:0]                  busRdata,
  input  logic [NUM_PINS-1:0]          pinIn,
  output logic [NUM_PINS-1:0]          pinOut,
  output logic [NUM_PINS-1:0]          pinOe,
  output logic [NUM_PINS-1:0]          pullUpEn,
  output logic [NUM_PINS-1:0]          pullDnEn,
  output logic [NUM_PINS*DRV_BITS-1:0] drvCode,
  output logic                         irq
);
  busStrobe_t        strb;
  logic [BANK_W-1:0] bankIdx;

  gpio_ctrl #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_ctrl (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .strb(strb), .bankIdx(bankIdx)
  );

  gpio_datapath #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bankIdx(bankIdx),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .pullUpEn(pullUpEn),
    .pullDnEn(pullDnEn), .drvCode(drvCode), .irq(irq)
  );
endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic [31:0]       pinIn0,
  input logic [31:0]       pinOut0,
  input logic [31:0]       pinOe0,
  input logic [31:0]       pullUp0,
  input logic [31:0]       pullDn0,
  input logic [31:0]       pinOeAll,
  input logic              irq
);
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  logic wrAt, rdAt;
  assign wrAt = busSel & busWr;
  assign rdAt = busSel & ~busWr;

  p_dout_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrAt && busAddr == ADDR_W'(12'h004)) |=> (pinOut0 == $past(busWdata)));

  p_oe_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrAt && busAddr == ADDR_W'(12'h008)) |=> (pinOe0 == $past(busWdata)));

  p_input_latency_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 2'd2 && rdAt && busAddr == ADDR_W'(12'h000)) |-> (busRdata == $past(pinIn0, 2)));

  p_clear_reads_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdAt && busAddr == ADDR_W'(12'h024)) |-> (busRdata == 32'h0));

  p_masked_drives_irq_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdAt && busAddr == ADDR_W'(12'h020) && busRdata != 32'h0) |-> irq);

  p_pull_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrAt && busAddr == ADDR_W'(12'h038) && busWdata == 32'h0) |=> (pullUp0 == 32'h0 && pullDn0 == 32'h0));

  p_reset_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    (cyc == 2'd0) |-> (!irq && pinOeAll == 32'h0));
endmodule

bind gpio_bank_top gpio_bank_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .busWdata(busWdata), .busRdata(busRdata), .pinIn0(pinIn[31:0]),
  .pinOut0(pinOut[31:0]), .pinOe0(pinOe[31:0]), .pullUp0(pullUpEn[31:0]),
  .pullDn0(pullDnEn[31:0]), .pinOeAll(pinOe[63:32] | pinOe[31:0]), .irq(irq)
);

// File: tb/gpio_bank_top_bench.sv
module gpio_bank_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 2;
  localparam int NP = NB * 32;
  localparam int NT = 15;

  localparam logic [11:0] T_ADDR [NT] = '{12'h004, 12'h208, 12'h20C, 12'h010, 12'h014,
    12'h218, 12'h034, 12'h038, 12'h258, 12'h05C, 12'h060, 12'h058, 12'h024, 12'h01C, 12'h404};
  localparam logic [31:0] T_DATA [NT] = '{32'hA5A50F0F, 32'h0000FFFF, 32'h12345678, 32'h0F0F0000,
    32'h00FF00FF, 32'h80000001, 32'h0000000C, 32'h00000006, 32'h00000001, 32'h00000010,
    32'h00000010, 32'h00000010, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hDEADBEEF};
  localparam logic [31:0] T_EXP [NT] = '{32'hA5A50F0F, 32'h0000FFFF, 32'h12345678, 32'h0F0F0000,
    32'h00FF00FF, 32'h80000001, 32'h0000000C, 32'h00000006, 32'h00000001, 32'h00000010,
    32'h00000010, 32'h00000010, 32'h0, 32'h0, 32'h0};

  logic clk = 1'b0, rstN = 1'b0, busSel = 1'b0, busWr = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata, rd;
  logic [NP-1:0] pinIn = '0, pinOut, pinOe, pullUpEn, pullDnEn;
  logic [NP*3-1:0] drvCode;
  logic irq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank_top u_gpio_bank_top (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .pullUpEn(pullUpEn), .pullDnEn(pullDnEn), .drvCode(drvCode), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R12 irq", {31'h0, irq}, 32'h0);
    chk("R12 pinOe", pinOe[31:0] | pinOe[63:32], 32'h0);
    busRead(12'h004, rd); chk("R12 dout", rd, 32'h0);
    busRead(12'h01C, rd); chk("R12 raw", rd, 32'h0);

    for (int i = 0; i < NT; i++) begin
      busWrite(T_ADDR[i], T_DATA[i]);
      busRead(T_ADDR[i], rd);
      chk("R1/R2 table readback", rd, T_EXP[i]);
    end
    chk("R2 pinOut bank0", pinOut[31:0], 32'hA5A50F0F);
    chk("R2 pinOe bank1", pinOe[63:32], 32'h0000FFFF);
    chk("R10 pull up", pullUpEn[31:0], 32'h4);
    chk("R10 pull down", pullDnEn[31:0], 32'h2);
    chk("R11 pin4 code", {29'h0, drvCode[14:12]}, 32'h7);
    chk("R11 pin32 code", {29'h0, drvCode[98:96]}, 32'h1);
    chk("R9 irq after table", {31'h0, irq}, 32'h0);
    busWrite(12'h038, 32'h0);
    chk("R10 pull off up", pullUpEn[31:0], 32'h0);
    chk("R10 pull off dn", pullDnEn[31:0], 32'h0);

    busWrite(12'h00C, 32'h0); busWrite(12'h010, 32'h0); busWrite(12'h014, 32'h1);
    busWrite(12'h018, 32'h0); busWrite(12'h20C, 32'h0); busWrite(12'h218, 32'h0);
    busWrite(12'h224, 32'hFFFFFFFF); busWrite(12'h024, 32'hFFFFFFFF);

    pinIn[1:0] = 2'b11;
    @(negedge clk); busRead(12'h000, rd); chk("R3 din one clock", rd & 32'h3, 32'h0);
    @(negedge clk); busRead(12'h000, rd); chk("R3 din two clocks", rd & 32'h3, 32'h3);
    busRead(12'h01C, rd); chk("R4 raw two clocks", rd, 32'h0);
    @(negedge clk); busRead(12'h01C, rd); chk("R4 rising only pin0", rd, 32'h1);
    chk("R9 irq masked off", {31'h0, irq}, 32'h0);
    busWrite(12'h018, 32'h3);
    chk("R9 irq unmasked", {31'h0, irq}, 32'h1);
    busRead(12'h020, rd); chk("R9 masked status", rd, 32'h1);
    pinIn[1] = 1'b0;
    repeat (3) @(negedge clk);
    busRead(12'h01C, rd); chk("R4 falling pin1", rd, 32'h3);

    busWrite(12'h024, 32'h0); busRead(12'h01C, rd); chk("R7 clear zero no effect", rd, 32'h3);
    busWrite(12'h024, 32'h1); busRead(12'h01C, rd); chk("R7 clear pin0", rd, 32'h2);
    busWrite(12'h024, 32'h2); busRead(12'h01C, rd); chk("R7 clear pin1", rd, 32'h0);
    chk("R9 irq after clear", {31'h0, irq}, 32'h0);

    busWrite(12'h010, 32'h4); busWrite(12'h014, 32'h5);
    pinIn[2] = 1'b1; repeat (3) @(negedge clk);
    busRead(12'h01C, rd); chk("R5 dual rise", rd, 32'h4);
    busWrite(12'h024, 32'h4);
    pinIn[2] = 1'b0; repeat (3) @(negedge clk);
    busRead(12'h01C, rd); chk("R5 dual fall", rd, 32'h4);
    busWrite(12'h024, 32'h4);
    busRead(12'h01C, rd); chk("R7 cleared before collision", rd, 32'h0);

    pinIn[2] = 1'b1;
    @(negedge clk);
    busWrite(12'h024, 32'h4);
    busRead(12'h01C, rd); chk("R8 edge beats clear", rd, 32'h4);
    busWrite(12'h024, 32'h4);
    busRead(12'h01C, rd); chk("R7 clear after collision", rd, 32'h0);

    busWrite(12'h014, 32'hD); busWrite(12'h00C, 32'h8);
    @(negedge clk);
    busRead(12'h01C, rd); chk("R6 level inactive", rd, 32'h0);
    pinIn[3] = 1'b1; repeat (3) @(negedge clk);
    busRead(12'h01C, rd); chk("R6 level active", rd, 32'h8);
    busWrite(12'h024, 32'h8);
    busRead(12'h01C, rd); chk("R6 level survives clear", rd, 32'h8);
    pinIn[3] = 1'b0; repeat (2) @(negedge clk);
    busRead(12'h01C, rd); chk("R6 level still held", rd, 32'h8);
    @(negedge clk);
    busRead(12'h01C, rd); chk("R6 level dropped", rd, 32'h0);

    busWrite(12'h018, 32'h0); busWrite(12'h214, 32'h100); busWrite(12'h218, 32'h100);
    pinIn[40] = 1'b1; repeat (3) @(negedge clk);
    busRead(12'h200, rd); chk("R1 bank1 input bit8", rd, 32'h100);
    busRead(12'h21C, rd); chk("R1 bank1 raw", rd, 32'h100);
    busRead(12'h01C, rd); chk("R1 bank0 untouched", rd, 32'h0);
    busRead(12'h220, rd); chk("R9 bank1 masked", rd, 32'h100);
    chk("R9 irq from bank1", {31'h0, irq}, 32'h1);
    busRead(12'h400, rd); chk("R1 out of range read", rd, 32'h0);

    finishRun();
  end
endmodule